// File: doc/BRIEF.md
# Pipelined Karatsuba Multiplier for a Wide Floating-Point Format

This block multiplies two operands of a very wide floating-point format and produces one rounded-down product per clock. Each word holds a sign at the top, a 63-bit biased exponent below it, and a mantissa that occupies every remaining bit. The mantissa carries its leading one explicitly at its top bit. The operand width is set at elaboration time.

The mantissa product is built by recursive Karatsuba splitting. At each level the operands are halved, and three half-size products replace the four of schoolbook multiplication. The recursion stops once an operand is no wider than a base width parameter. Below that, a plain multiplier forms the product. Every level is registered, so the unit accepts a new operand pair each cycle. The result appears a fixed number of cycles later, together with a valid flag. The exponent and sign travel through a matched delay line, and a last stage normalises the double-width product and truncates it.

Top module: `wfp_mul`

## Requirements
- R1: A word of TOTAL_W bits (a multiple of 512) holds the sign at bit TOTAL_W-1, the exponent in the 63 bits below it, and the mantissa in bits MW-1..0, where MW = TOTAL_W-64. A nonzero mantissa m with exponent e stands for m·2^-(MW-1)·2^(e-B), where B = 2^62-1. In this encoding 1.0 is the mantissa with only bit MW-1 set and exponent B.
- R2: The result sign is the XOR of the two operand signs, including when the result is zero.
- R3: Let P be the 2·MW-bit product of the mantissas. If bit 2·MW-1 of P is set, the result mantissa is P[2·MW-1:MW]. Otherwise it is P[2·MW-2:MW-1]. The discarded low bits are dropped without rounding.
- R4: The result exponent is ea+eb-B modulo 2^63, plus one when bit 2·MW-1 of P is set.
- R5: If either mantissa is zero, the result mantissa and exponent are all zero.
- R6: With L the number of times the rule w := ceil(w/2)+1 is applied, starting from w = MW, until w ≤ max(BASE_W,4), each result appears exactly 2·L+2 cycles after its operands. out_valid is in_valid delayed by that amount. For the defaults this is 8 cycles.
- R7: While rst is high, out_valid and out_p are zero. Operands presented while reset is high never produce a result.
- R8: A new operand pair is accepted every cycle, including back to back with no gaps. Results leave in issue order and do not depend on neighbouring operands.
- R9: The result value does not depend on BASE_W. Only the latency changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_a | input | TOTAL_W | First operand |
| in_b | input | TOTAL_W | Second operand |
| out_valid | output | 1 | Result present this cycle |
| out_p | output | TOTAL_W | Product |

## Verification
The bench targets three families of corner cases.

- Mantissa products that land just below 2 and products of all-ones mantissas. These sit on both sides of the normalising shift, so a design that picks the wrong half or forgets the exponent increment is off by a factor of two.
- Exponents at the top of their range. These catch a design that saturates or sign-extends instead of wrapping modulo 2^63.
- Zero operands with large exponents and set signs. These catch a design that keeps an exponent or drops the sign.

A second instance with a much smaller base width must match the default instance bit for bit. Any slip in Karatsuba's middle term shows up there as a corrupted central band of the mantissa. Random back-to-back traffic with bubbles checks that each result arrives at exactly the stated latency and in order.

// File: rtl/wfp_pkg.sv
`timescale 1ns/1ps
package wfp_pkg;

    // Exponent field width and bias of the word format
    localparam int EXP_W = 63;
    localparam logic [EXP_W-1:0] EXP_BIAS = {1'b0, {(EXP_W-1){1'b1}}};

    // Fields that bypass the mantissa multiplier
    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic             zero;
    } side_t;

    // Smallest base width that keeps the recursion shrinking
    function automatic int eff_base(input int base);
        return (base < 4) ? 4 : base;
    endfunction

    // Number of Karatsuba split levels for a given operand width
    function automatic int kara_levels(input int w, input int base);
        int cur = w;
        int n   = 0;
        while (cur > eff_base(base)) begin
            cur = (cur + 1) / 2 + 1;
            n++;
        end
        return n;
    endfunction

    // Cycles through the recursive multiplier: leaf register plus two per level
    function automatic int kara_latency(input int w, input int base);
        return 2 * kara_levels(w, base) + 1;
    endfunction

endpackage

// File: rtl/wfp_pipe.sv
`timescale 1ns/1ps
module wfp_pipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < DEPTH; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[DEPTH-1];
endmodule

// File: rtl/wfp_kmul.sv
`timescale 1ns/1ps
module wfp_kmul #(
    parameter int W    = 64,
    parameter int BASE = 64
) (
    input  logic           clk,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    import wfp_pkg::*;

    localparam int BEFF = eff_base(BASE);

    generate
        if (W <= BEFF) begin : g_leaf
            logic [2*W-1:0] prod_q;
            always_ff @(posedge clk) begin
                prod_q <= {{W{1'b0}}, a} * {{W{1'b0}}, b};
            end
            assign p = prod_q;
        end else begin : g_split
            // Upper half no wider than lower; all three children S bits wide
            localparam int H  = (W + 1) / 2;
            localparam int L  = W - H;
            localparam int S  = H + 1;
            localparam int PW = 2 * W;

            logic [S-1:0]   lo_a_q, hi_a_q, sm_a_q;
            logic [S-1:0]   lo_b_q, hi_b_q, sm_b_q;
            logic [2*S-1:0] z_lo, z_hi, z_sm;
            logic [PW-1:0]  e_lo, e_hi, e_sm, mid, total;
            logic [PW-1:0]  prod_q;

            always_ff @(posedge clk) begin
                lo_a_q <= {1'b0, a[H-1:0]};
                hi_a_q <= {{(S-L){1'b0}}, a[W-1:H]};
                sm_a_q <= {1'b0, a[H-1:0]} + {{(S-L){1'b0}}, a[W-1:H]};
                lo_b_q <= {1'b0, b[H-1:0]};
                hi_b_q <= {{(S-L){1'b0}}, b[W-1:H]};
                sm_b_q <= {1'b0, b[H-1:0]} + {{(S-L){1'b0}}, b[W-1:H]};
            end

            wfp_kmul #(.W(S), .BASE(BASE)) u_lo (.clk(clk), .a(lo_a_q), .b(lo_b_q), .p(z_lo));
            wfp_kmul #(.W(S), .BASE(BASE)) u_hi (.clk(clk), .a(hi_a_q), .b(hi_b_q), .p(z_hi));
            wfp_kmul #(.W(S), .BASE(BASE)) u_sm (.clk(clk), .a(sm_a_q), .b(sm_b_q), .p(z_sm));

            always_comb begin
                e_lo  = {{(PW-2*S){1'b0}}, z_lo};
                e_hi  = {{(PW-2*S){1'b0}}, z_hi};
                e_sm  = {{(PW-2*S){1'b0}}, z_sm};
                mid   = e_sm - e_lo - e_hi;
                total = (e_hi << (2 * H)) + (mid << H) + e_lo;
            end

            always_ff @(posedge clk) begin
                prod_q <= total;
            end
            assign p = prod_q;
        end
    endgenerate
endmodule

// File: rtl/wfp_norm.sv
`timescale 1ns/1ps
module wfp_norm #(
    parameter int MW = 448
) (
    input  logic [2*MW-1:0]            prod,
    input  wfp_pkg::side_t             side,
    output logic [MW+wfp_pkg::EXP_W:0] word
);
    import wfp_pkg::*;

    logic          carry;
    logic [MW-1:0] hi_m, lo_m;
    logic [MW-2:0] unused_tail;

    assign carry = prod[2*MW-1];
    assign hi_m  = prod[2*MW-1:MW];
    assign {lo_m, unused_tail} = prod[2*MW-2:0];

    always_comb begin
        if (side.zero) begin
            word = {side.sgn, {(EXP_W+MW){1'b0}}};
        end else begin
            word = {side.sgn,
                    side.exp + {{(EXP_W-1){1'b0}}, carry},
                    carry ? hi_m : lo_m};
        end
    end
endmodule

// File: rtl/wfp_mul.sv
`timescale 1ns/1ps
module wfp_mul #(
    parameter int TOTAL_W = 512,
    parameter int BASE_W  = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [TOTAL_W-1:0] in_a,
    input  logic [TOTAL_W-1:0] in_b,
    output logic               out_valid,
    output logic [TOTAL_W-1:0] out_p
);
    import wfp_pkg::*;

    localparam int MW   = TOTAL_W - 1 - EXP_W;
    localparam int KLAT = kara_latency(MW, BASE_W);
    localparam int SW   = $bits(side_t);

    side_t             side_in, side_out;
    logic [SW:0]       pipe_q;
    logic              v_late;
    logic [2*MW-1:0]   prod;
    logic [TOTAL_W-1:0] word;

    always_comb begin
        side_in.sgn  = in_a[TOTAL_W-1] ^ in_b[TOTAL_W-1];
        side_in.exp  = in_a[TOTAL_W-2 -: EXP_W] + in_b[TOTAL_W-2 -: EXP_W] - EXP_BIAS;
        side_in.zero = ~|in_a[MW-1:0] | ~|in_b[MW-1:0];
    end

    wfp_pipe #(.WIDTH(SW + 1), .DEPTH(KLAT)) u_side (
        .clk (clk),
        .rst (rst),
        .d   ({in_valid, side_in}),
        .q   (pipe_q)
    );

    assign v_late   = pipe_q[SW];
    assign side_out = side_t'(pipe_q[SW-1:0]);

    wfp_kmul #(.W(MW), .BASE(BASE_W)) u_mant (
        .clk (clk),
        .a   (in_a[MW-1:0]),
        .b   (in_b[MW-1:0]),
        .p   (prod)
    );

    wfp_norm #(.MW(MW)) u_norm (
        .prod (prod),
        .side (side_out),
        .word (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_p     <= '0;
        end else begin
            out_valid <= v_late;
            out_p     <= word;
        end
    end
endmodule

// File: rtl/wfp_mul_chk.sv
`timescale 1ns/1ps
module wfp_mul_chk #(
    parameter int TOTAL_W = 512,
    parameter int BASE_W  = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic [TOTAL_W-1:0] in_a,
    input logic [TOTAL_W-1:0] in_b,
    input logic               out_valid,
    input logic [TOTAL_W-1:0] out_p
);
    import wfp_pkg::*;

    localparam int MW  = TOTAL_W - 1 - EXP_W;
    localparam int LAT = kara_latency(MW, BASE_W) + 1;

    logic [LAT-1:0] v_hist, s_hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_hist <= '0;
            s_hist <= '0;
        end else begin
            v_hist <= {v_hist[LAT-2:0], in_valid};
            s_hist <= {s_hist[LAT-2:0], in_a[TOTAL_W-1] ^ in_b[TOTAL_W-1]};
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_hist[LAT-1]); // R6

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_p[TOTAL_W-1] == s_hist[LAT-1]); // R2

    AST_LEAD_ONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && |out_p[MW-1:0]) |-> out_p[MW-1]); // R3

    AST_ZERO_EXP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !(|out_p[MW-1:0])) |-> out_p[TOTAL_W-2 -: EXP_W] == '0); // R5
endmodule

bind wfp_mul wfp_mul_chk #(.TOTAL_W(TOTAL_W), .BASE_W(BASE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_p     (out_p)
);

// File: tb/tb_wfp_mul.sv
`timescale 1ns/1ps
module tb_wfp_mul;
    localparam int TW = 512;
    localparam int EW = 63;
    localparam int MW = TW - 1 - EW;
    localparam int NV = 4096;
    localparam logic [EW-1:0] BIAS = {1'b0, {(EW-1){1'b1}}};
    localparam logic [MW-1:0] ONE  = {1'b1, {(MW-1){1'b0}}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [TW-1:0] in_a = '0, in_b = '0;
    logic          ov0, ov1;
    logic [TW-1:0] op0, op1;

    always #2.5 clk = ~clk;

    wfp_mul dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
                 .out_valid(ov0), .out_p(op0));
    wfp_mul #(.BASE_W(16)) dut_fine (.clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a),
                 .in_b(in_b), .out_valid(ov1), .out_p(op1));

    int checks = 0, fails = 0, cyc = 0;
    int wr = 0, rd0 = 0, rd1 = 0, lat0, lat1;
    bit done = 1'b0;
    logic [TW-1:0] exp_mem [NV];
    int            iss_mem [NV];
    string         tag_mem [NV];

    // R6 latency rule, written from the requirement
    function automatic int exp_lat(input int base);
        int w = MW;
        int n = 0;
        int b = (base < 4) ? 4 : base;
        while (w > b) begin
            w = (w + 1) / 2 + 1;
            n++;
        end
        return 2 * n + 2;
    endfunction

    // R1..R5 reference result
    function automatic logic [TW-1:0] model(input logic [TW-1:0] a, input logic [TW-1:0] b);
        logic [2*MW-1:0] p;
        logic [EW-1:0]   e;
        logic [MW-1:0]   m;
        logic            s;
        s = a[TW-1] ^ b[TW-1];
        if (a[MW-1:0] == '0 || b[MW-1:0] == '0) return {s, {(EW+MW){1'b0}}};
        p = {{MW{1'b0}}, a[MW-1:0]} * {{MW{1'b0}}, b[MW-1:0]};
        e = a[TW-2 -: EW] + b[TW-2 -: EW] - BIAS;
        if (p[2*MW-1]) begin
            m = p[2*MW-1:MW];
            e = e + 1'b1;
        end else begin
            m = p[2*MW-2:MW-1];
        end
        return {s, e, m};
    endfunction

    function automatic logic [TW-1:0] mk(input logic s, input logic [EW-1:0] e, input logic [MW-1:0] m);
        return {s, e, m};
    endfunction

    function automatic logic [TW-1:0] rand_op();
        logic [TW-1:0] r;
        for (int i = 0; i < TW / 32; i++) r[i*32 +: 32] = $urandom;
        r[MW-1] = 1'b1;
        if ($urandom % 16 == 0) r[MW-1:0] = '0;
        if ($urandom % 2 == 1) r[TW-2 -: EW] = BIAS + EW'($urandom % 256) - EW'(128);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [TW-1:0] act, input logic [TW-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic scan(input int which);
        logic          ov;
        logic [TW-1:0] op;
        int            rd, lat;
        string         sfx;
        if (which == 0) begin ov = ov0; op = op0; rd = rd0; lat = lat0; sfx = ""; end
        else            begin ov = ov1; op = op1; rd = rd1; lat = lat1; sfx = " R9 base16"; end
        if (ov) begin
            if (rd >= wr) begin
                check(1'b0, {"R6 unexpected out_valid", sfx}, 1, 0);
            end else begin
                check(cyc - iss_mem[rd] == lat, {"R6 latency", sfx}, TW'(cyc - iss_mem[rd]), TW'(lat));
                check(op === exp_mem[rd], {tag_mem[rd], sfx}, op, exp_mem[rd]);
                rd++;
            end
        end else if (rd < wr && cyc - iss_mem[rd] >= lat) begin
            check(1'b0, {"R6 missing out_valid", sfx}, 0, 1);
            rd++;
        end
        if (which == 0) rd0 = rd; else rd1 = rd;
    endtask

    task automatic cycle(input logic v, input logic [TW-1:0] a, input logic [TW-1:0] b, input string tag);
        @(negedge clk);
        cyc++;
        scan(0);
        scan(1);
        in_valid = v;
        in_a     = a;
        in_b     = b;
        if (v && !rst) begin
            exp_mem[wr] = model(a, b);
            iss_mem[wr] = cyc;
            tag_mem[wr] = tag;
            wr++;
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        lat0 = exp_lat(64);
        lat1 = exp_lat(16);
        // R7: operands offered during reset must vanish
        for (int i = 0; i < 6; i++) cycle(1'b1, rand_op(), rand_op(), "R7");
        @(negedge clk);
        check(!ov0 && op0 == '0, "R7 reset state", {ov0, op0[TW-2:0]}, '0);
        check(!ov1 && op1 == '0, "R7 reset state R9", {ov1, op1[TW-2:0]}, '0);
        rst = 1'b0;
        in_valid = 1'b0;
        // Directed corners
        cycle(1'b1, mk(0, BIAS, ONE), mk(0, BIAS, ONE), "R1 one times one");
        cycle(1'b1, mk(1, BIAS, ONE), mk(0, BIAS + 3, ONE | 1), "R2 mixed signs");
        cycle(1'b1, mk(1, BIAS - 5, ONE | 7), mk(1, BIAS, ONE | 9), "R2 both negative");
        cycle(1'b1, mk(0, BIAS, '1), mk(0, BIAS, '1), "R3 carry path");
        cycle(1'b1, mk(0, BIAS, ONE | 1), mk(0, BIAS, ONE | 3), "R3 no carry path");
        cycle(1'b1, mk(0, '1, '1), mk(0, '1, '1), "R4 exponent wrap");
        cycle(1'b1, mk(1, '0, ONE), mk(0, '0, ONE), "R4 low exponent");
        cycle(1'b1, mk(1, '1, '0), mk(0, BIAS, ONE), "R5 zero first");
        cycle(1'b1, mk(0, BIAS, '1), mk(1, 12345, '0), "R5 zero second");
        cycle(1'b0, '0, '0, "");
        cycle(1'b1, mk(1, '1, '0), mk(1, '1, '0), "R5 both zero");
        for (int i = 0; i < 3; i++) cycle(1'b0, '0, '0, "");
        // R8: random traffic with and without bubbles
        for (int i = 0; i < 300; i++) cycle(1'b1, rand_op(), rand_op(), "R8 back to back");
        for (int i = 0; i < 500; i++) cycle(($urandom % 4) != 0, rand_op(), rand_op(), "R8 with bubbles");
        for (int i = 0; i < 3 * lat1; i++) cycle(1'b0, '0, '0, "");
        check(rd0 == wr, "R8 all results returned", TW'(rd0), TW'(wr));
        check(rd1 == wr, "R9 all results returned", TW'(rd1), TW'(wr));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R8 watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule